// File: doc/BRIEF.md
# Steerable Multiplier-Resolution Watchdog

This block watches a processor for signs of life. Software programs a single 8-bit control register with a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is the multiplier times the chosen resolution (1/16 s, 1/4 s, 1 s or 4 s). If software does not touch the register within that time, the block either latches a flag and pulls an interrupt pin low, or it emits an active-low reset pulse of fixed length and wipes its own register. The choice depends on the steering bit.

Time comes from a one-cycle `tick` strobe at 1024 Hz, derived from a 32.768 kHz oscillator. The block also owns the mux for the shared active-low interrupt pin. That pin carries the watchdog interrupt, an alarm interrupt from a neighbouring block, or a 512 Hz square wave for frequency measurement. The square wave toggles once per tick.

Register accesses reach the block as one-cycle strobes. `acc_wd` selects the watchdog register when high and the flags register when low.

Top module: `steer_wdog`

## Requirements
- R1: After reset, `wd_cfg` is 00h, `wd_flag` is 0, `ft_clr` is 0, and both `irq_pin_n` and `wd_rst_n` are high.
- R2: The register layout is as follows: bit 7 is the steering bit, bits 6:2 are the multiplier M and bits 1:0 are the resolution code C.
- R3: The timeout is M × 4^C × TICKS_PER_UNIT ticks, counted from the last restart.
- R4: Any read or write of the watchdog register (`acc_vld` with `acc_wd`=1) restarts the count from zero.
- R5: When M is 0, the count never expires. This includes the value 00h and any non-zero resolution code.
- R6: With the steering bit at 0, an expiry sets `wd_flag` and drives `irq_pin_n` low. The count then restarts, so a further expiry follows after another full timeout.
- R7: The watchdog interrupt is released by a read of the flags register, or by any read or write of the watchdog register. `wd_flag` is cleared only by a read of the flags register. A write to the flags register changes neither.
- R8: With the steering bit at 1, an expiry holds `wd_rst_n` low for exactly PULSE_TICKS ticks. In the same clock edge it clears `wd_cfg` to 00h and pulses `ft_clr` for one cycle. `wd_flag` is left unchanged.
- R9: Frequency-test mode is on when all of the following hold: `ft_bit`=1, `alarm_en`=0, `osc_run`=1, and either the steering bit is 1 or `wd_cfg` is 00h. In this mode `irq_pin_n` starts high and inverts on every tick. When the mode is off and no interrupt is pending, the pin stays high.
- R10: A pending watchdog interrupt or `alarm_irq` drives `irq_pin_n` low, overriding the test square wave. An enabled watchdog steered to the pin suppresses test mode entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 1024 Hz |
| acc_vld | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wd | input | 1 | 1 = watchdog register, 0 = flags register |
| acc_wdata | input | 8 | Write data |
| ft_bit | input | 1 | Frequency-test request bit |
| alarm_en | input | 1 | Alarm interrupt enable |
| alarm_irq | input | 1 | Pending alarm interrupt |
| osc_run | input | 1 | Oscillator running |
| wd_cfg | output | 8 | Watchdog register contents |
| wd_flag | output | 1 | Watchdog flag (flags register bit 7) |
| irq_pin_n | output | 1 | Shared active-low interrupt / test pin |
| wd_rst_n | output | 1 | Active-low reset pulse |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
The bench builds the block with TICKS_PER_UNIT=2 and PULSE_TICKS=5. With these values the longest timeout is 3968 ticks, so all 32 multiplier values are swept at the finest resolution. Every resolution code is then swept with small and maximal multipliers, and each expiry is checked on the exact tick against M × 4^C × 2. The short pulse length lets the bench count the reset pulse tick by tick and confirm its release edge. The bench also tracks the 512 Hz phase through every gating input.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
  localparam int CFG_W  = 8;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int RES_N  = 1 << RES_W;
  // each resolution step is four times the previous one
  localparam int RES_LOG_STEP = 2;
  localparam int RES_LOG_MAX  = RES_LOG_STEP * (RES_N - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_int_n = pipe_q[1];
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import steer_wdog_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic              expire
);
  localparam int TPU_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam int LIM_W = MULT_W + RES_LOG_MAX + TPU_W + 1;

  logic [LIM_W-1:0] span [RES_N];
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             active;
  logic             cnt_en;

  // one candidate span per resolution code
  for (genvar g = 0; g < RES_N; g++) begin : g_span
    assign span[g] = (LIM_W'(mult) * LIM_W'(TICKS_PER_UNIT)) << (RES_LOG_STEP * g);
  end

  assign limit  = span[res];
  assign active = (mult != '0);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = 1'b0;
    if (restart || !active) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (tick) begin
      cnt_en = 1'b1;
      if (cnt_q == limit - LIM_W'(1)) begin
        cnt_d  = '0;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q + LIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
  parameter int PULSE_TICKS = 102
)(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic pulse_n
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_d  = left_q;
    left_en = 1'b0;
    if (start) begin
      left_d  = PW'(PULSE_TICKS);
      left_en = 1'b1;
    end else if (tick && left_q != '0) begin
      left_d  = left_q - PW'(1);
      left_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdg_pin_mux.sv
module wdg_pin_mux
  import steer_wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    ft_bit,
  input  logic    alarm_en,
  input  logic    osc_run,
  input  wd_cfg_t cfg,
  input  logic    wd_irq,
  input  logic    alarm_irq,
  output logic    pin_n
);
  logic sq_q, sq_d, sq_en;
  logic test_on;

  // the watchdog owns the pin whenever it is armed and steered to it
  assign test_on = ft_bit && !alarm_en && osc_run &&
                   (cfg.steer || cfg == wd_cfg_t'('0));

  always_comb begin
    sq_d  = sq_q;
    sq_en = 1'b0;
    if (!test_on) begin
      sq_d  = 1'b1;
      sq_en = !sq_q;
    end else if (tick) begin
      sq_d  = !sq_q;
      sq_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sq_q <= 1'b1;
    else if (sq_en) sq_q <= sq_d;
  end

  always_comb begin
    if (wd_irq || alarm_irq) pin_n = 1'b0;
    else if (test_on)        pin_n = sq_q;
    else                     pin_n = 1'b1;
  end
endmodule

// File: rtl/steer_wdog.sv
module steer_wdog
  import steer_wdog_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 64,
  parameter int PULSE_TICKS    = 102
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic             acc_wd,
  input  logic [CFG_W-1:0] acc_wdata,
  input  logic             ft_bit,
  input  logic             alarm_en,
  input  logic             alarm_irq,
  input  logic             osc_run,
  output logic [CFG_W-1:0] wd_cfg,
  output logic             wd_flag,
  output logic             irq_pin_n,
  output logic             wd_rst_n,
  output logic             ft_clr
);
  logic    rst_int_n;
  wd_cfg_t cfg_q, cfg_d;
  logic    cfg_en;
  logic    flag_q, flag_d;
  logic    irq_q, irq_d;
  logic    clr_q, clr_d;
  logic    wd_touch, wd_write, flags_read;
  logic    expire, exp_irq, exp_rst;

  wdg_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign wd_touch   = acc_vld && acc_wd;
  assign wd_write   = wd_touch && acc_wr;
  assign flags_read = acc_vld && !acc_wd && !acc_wr;

  wdg_countdown #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_count (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .restart (wd_touch),
    .mult    (cfg_q.mult),
    .res     (cfg_q.res),
    .expire  (expire)
  );

  assign exp_irq = expire && !cfg_q.steer;
  assign exp_rst = expire &&  cfg_q.steer;

  // next-state logic
  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (wd_write) begin
      cfg_d  = wd_cfg_t'(acc_wdata);
      cfg_en = 1'b1;
    end else if (exp_rst) begin
      cfg_d  = wd_cfg_t'('0);
      cfg_en = 1'b1;
    end

    flag_d = flag_q;
    if (exp_irq)         flag_d = 1'b1;
    else if (flags_read) flag_d = 1'b0;

    irq_d = irq_q;
    if (exp_irq)                     irq_d = 1'b1;
    else if (flags_read || wd_touch) irq_d = 1'b0;

    clr_d = exp_rst;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q  <= wd_cfg_t'('0);
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
      clr_q  <= clr_d;
    end
  end

  wdg_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .start   (exp_rst),
    .pulse_n (wd_rst_n)
  );

  wdg_pin_mux u_pin (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .ft_bit    (ft_bit),
    .alarm_en  (alarm_en),
    .osc_run   (osc_run),
    .cfg       (cfg_q),
    .wd_irq    (irq_q),
    .alarm_irq (alarm_irq),
    .pin_n     (irq_pin_n)
  );

  assign wd_cfg  = cfg_q;
  assign wd_flag = flag_q;
  assign ft_clr  = clr_q;
endmodule

// File: rtl/steer_wdog_chk.sv
module steer_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_vld,
  input logic       acc_wr,
  input logic       acc_wd,
  input logic [7:0] wd_cfg,
  input logic       wd_flag,
  input logic       irq_pin_n,
  input logic       wd_rst_n,
  input logic       ft_clr
);
  // R4: an access to the watchdog register never coincides with an expiry
  assert_touch_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wd) |=> (!$rose(wd_flag) && !$fell(wd_rst_n)));

  // R5 and R6: the flag rises only from an armed watchdog steered to the interrupt
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> ($past(wd_cfg[6:2]) != 5'd0 && !$past(wd_cfg[7])));

  // R10: a new watchdog interrupt owns the pin
  assert_irq_on_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> !irq_pin_n);

  // R7: only a read of the flags register clears the flag
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> $past(acc_vld && !acc_wr && !acc_wd));

  // R8: the reset pulse starts together with the register wipe and the clear request
  assert_pulse_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> (wd_cfg == 8'h00 && ft_clr && !$rose(wd_flag)));

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr |=> !ft_clr);
endmodule

bind steer_wdog steer_wdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_vld   (acc_vld),
  .acc_wr    (acc_wr),
  .acc_wd    (acc_wd),
  .wd_cfg    (wd_cfg),
  .wd_flag   (wd_flag),
  .irq_pin_n (irq_pin_n),
  .wd_rst_n  (wd_rst_n),
  .ft_clr    (ft_clr)
);

// File: tb/steer_wdog_tb.sv
module steer_wdog_tb;
  localparam int TPU   = 2;
  localparam int PULSE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       acc_vld = 1'b0, acc_wr = 1'b0, acc_wd = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic       ft_bit = 1'b0, alarm_en = 1'b0, alarm_irq = 1'b0, osc_run = 1'b1;
  logic [7:0] wd_cfg;
  logic       wd_flag, irq_pin_n, wd_rst_n, ft_clr;

  int n_cmp = 0;
  int n_bad = 0;

  steer_wdog #(.TICKS_PER_UNIT(TPU), .PULSE_TICKS(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wd(acc_wd), .acc_wdata(acc_wdata),
    .ft_bit(ft_bit), .alarm_en(alarm_en), .alarm_irq(alarm_irq), .osc_run(osc_run),
    .wd_cfg(wd_cfg), .wd_flag(wd_flag), .irq_pin_n(irq_pin_n),
    .wd_rst_n(wd_rst_n), .ft_clr(ft_clr)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic acc(logic wr, logic wd, logic [7:0] d);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_wd = wd; acc_wdata = d;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  function automatic int lim(int m, int r);
    return m * (1 << (2 * r)) * TPU;
  endfunction

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog expired: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic exp_sq;
    int   ml [5] = '{1, 2, 3, 17, 31};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cfg", wd_cfg, 0);
    check("R1 flag", wd_flag, 0);
    check("R1 pin", irq_pin_n, 1);
    check("R1 rst", wd_rst_n, 1);
    check("R1 ft_clr", ft_clr, 0);

    // R2 layout readback
    acc(1, 1, 8'b0_00011_10);
    check("R2 cfg readback", wd_cfg, 8'h0E);

    // R3 sweep of all multipliers at resolution 00
    for (int m = 1; m < 32; m++) begin
      acc(1, 1, {1'b0, 5'(m), 2'b00});
      tk(lim(m, 0) - 1);
      check("R3 early flag", wd_flag, 0);
      tk(1);
      check("R3 expiry flag", wd_flag, 1);
      check("R6 pin low", irq_pin_n, 0);
      acc(0, 0, 8'h00);
      check("R7 flags read clears flag", wd_flag, 0);
    end

    // R3 every resolution code
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 5; k++) begin
        acc(1, 1, {1'b0, 5'(ml[k]), 2'(r)});
        tk(lim(ml[k], r) - 1);
        check("R3 res early", wd_flag, 0);
        tk(1);
        check("R3 res expiry", wd_flag, 1);
        acc(0, 0, 8'h00);
        check("R7 cleared", irq_pin_n, 1);
      end
    end

    // R6 repeat after expiry
    acc(1, 1, {1'b0, 5'd3, 2'b00});
    tk(6);
    check("R6 first expiry", wd_flag, 1);
    acc(0, 0, 8'h00);
    tk(5);
    check("R6 before repeat", wd_flag, 0);
    tk(1);
    check("R6 repeat expiry", wd_flag, 1);
    acc(0, 0, 8'h00);

    // R4 restart by read
    acc(1, 1, {1'b0, 5'd2, 2'b01});
    tk(15);
    acc(0, 1, 8'h00);
    tk(15);
    check("R4 restarted no flag", wd_flag, 0);
    tk(1);
    check("R4 expiry after restart", wd_flag, 1);

    // R7 release paths
    acc(1, 0, 8'hFF);
    check("R7 flags write keeps flag", wd_flag, 1);
    check("R7 flags write keeps pin", irq_pin_n, 0);
    acc(0, 1, 8'h00);
    check("R7 wd read releases pin", irq_pin_n, 1);
    check("R7 wd read keeps flag", wd_flag, 1);
    acc(0, 0, 8'h00);
    check("R7 flags read clears", wd_flag, 0);

    // R5 disabled settings
    acc(1, 1, 8'h00);
    tk(300);
    check("R5 00h flag", wd_flag, 0);
    check("R5 00h rst", wd_rst_n, 1);
    acc(1, 1, 8'h03);
    tk(300);
    check("R5 mult0 flag", wd_flag, 0);
    check("R5 mult0 pin", irq_pin_n, 1);
    check("R5 mult0 cfg kept", wd_cfg, 8'h03);

    // R8 reset steering
    acc(1, 1, {1'b1, 5'd2, 2'b00});
    tk(3);
    check("R8 before expiry rst", wd_rst_n, 1);
    check("R8 cfg held", wd_cfg, 8'h88);
    tk(1);
    check("R8 rst low", wd_rst_n, 0);
    check("R8 cfg wiped", wd_cfg, 8'h00);
    check("R8 ft_clr", ft_clr, 1);
    check("R8 no flag", wd_flag, 0);
    @(negedge clk);
    check("R8 ft_clr single", ft_clr, 0);
    tk(PULSE - 1);
    check("R8 pulse held", wd_rst_n, 0);
    tk(1);
    check("R8 pulse released", wd_rst_n, 1);

    // R9 test mode with 00h
    @(negedge clk);
    ft_bit = 1'b1; alarm_en = 1'b0; osc_run = 1'b1;
    exp_sq = 1'b1;
    @(negedge clk);
    check("R9 start high", irq_pin_n, 1);
    for (int i = 0; i < 6; i++) begin
      tk(1);
      exp_sq = !exp_sq;
      check("R9 toggle", irq_pin_n, 32'(exp_sq));
    end
    alarm_en = 1'b1;
    @(negedge clk);
    check("R9 alarm_en gates", irq_pin_n, 1);
    tk(3);
    check("R9 alarm_en held", irq_pin_n, 1);
    alarm_en = 1'b0;
    @(negedge clk);
    check("R9 restart high", irq_pin_n, 1);
    tk(1);
    check("R9 restart toggle", irq_pin_n, 0);
    osc_run = 1'b0;
    tk(2);
    check("R9 osc stop gates", irq_pin_n, 1);
    acc(1, 1, 8'hFF);
    osc_run = 1'b1;
    @(negedge clk);
    check("R9 steer1 start", irq_pin_n, 1);
    tk(1);
    check("R9 steer1 toggle a", irq_pin_n, 0);
    tk(1);
    check("R9 steer1 toggle b", irq_pin_n, 1);

    // R10 priority on the pin
    acc(1, 1, 8'h7F);
    for (int i = 0; i < 4; i++) begin
      tk(1);
      check("R10 armed wd suppresses test", irq_pin_n, 1);
    end
    acc(1, 1, 8'h00);
    tk(1);
    check("R10 test resumes", irq_pin_n, 0);
    alarm_irq = 1'b1;
    tk(1);
    check("R10 alarm overrides", irq_pin_n, 0);
    tk(1);
    check("R10 alarm holds", irq_pin_n, 0);
    alarm_irq = 1'b0;
    ft_bit = 1'b0;
    @(negedge clk);
    check("R10 idle high", irq_pin_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule